// File: doc/BRIEF.md
# Flash Read Page Buffer Controller

This block serves reads from a slow flash array through two page buffers. A requester presents a 17-bit word address with a read strobe. If the addressed 32-byte page already sits in one of the buffers, the requested 64-bit doubleword comes straight back, one cycle later. Otherwise the block asks the array core for the whole page. While that fetch is outstanding the block raises busy. When the array reports that the page is ready, the block returns the wanted doubleword and, normally, keeps the page in a buffer for later hits.

Two side inputs shape this behaviour. With random-access mode set, a fetched page is passed through and is not stored. The shadow-select input switches reads to a small 512-byte shadow region. Any change of that input discards every stored match, so the read that follows always goes to the array. Write strobes are acknowledged and otherwise ignored: program and erase sequencing live elsewhere.

Top module: `flash_page_reader`

## Requirements
- R1: The block holds two page buffers. Each holds one 32-byte page tagged by address bits [16:3] plus the shadow-select state. Both buffers are invalid after reset, so the first read always fetches.
- R2: When a read accepted while busy is low matches a valid buffer, fetchReq stays low and rdValid is high exactly one cycle after the request, carrying the buffered doubleword.
- R3: On a miss, fetchReq rises the cycle after the request and holds fetchAddr = rdAddr[16:3] steady until pageReady. rdValid follows one cycle after pageReady. Doubleword k of a page is pageData[64k+63:64k], k is rdAddr[2:1], and rdAddr[0] has no effect on reads.
- R4: A page fetched on a normal miss goes into an invalid buffer if there is one (buffer 0 before buffer 1). Otherwise it replaces the buffer least recently hit or filled.
- R5: A miss taken with randomMode high returns its data but stores nothing. The buffer contents and the replacement order stay as they were.
- R6: When shadowSel has a different value than in the previous cycle, all buffer matches are cleared, so the next read is off-page even if it was buffered before.
- R7: A write strobe gives wrAck high in the following cycle. It starts no fetch, returns no read data and leaves the buffers unchanged.
- R8: With shadowSel high, a read addresses the shadow region. fetchShadow is 1 and fetchAddr is {10'b0, rdAddr[6:3]}. A shadow page never hits on a normal page with the same address, and a normal page never hits on a shadow page.
- R9: busy is high from the cycle after a miss is accepted through the cycle in which pageReady is seen. A read strobe while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read strobe, taken when busy is low |
| wrReq | input | 1 | Write strobe, acknowledged only |
| rdAddr | input | 17 | Word address of the read |
| randomMode | input | 1 | Fetched pages are not stored |
| shadowSel | input | 1 | Selects the shadow region |
| busy | output | 1 | A page fetch is outstanding |
| rdValid | output | 1 | rdData holds the requested doubleword |
| rdData | output | 64 | Returned doubleword |
| wrAck | output | 1 | Write acknowledge |
| fetchReq | output | 1 | Page fetch request to the array core |
| fetchAddr | output | 14 | Page address of the fetch |
| fetchShadow | output | 1 | Fetch targets the shadow region |
| pageReady | input | 1 | Array core presents a page this cycle |
| pageData | input | 256 | Fetched 32-byte page |

## Verification
A wrong valid bit, tag or replacement pointer does not corrupt data directly. It shows up as a fetch where a hit was due, or as a missing fetch, which shows up on fetchReq one cycle after the read. A stale buffer would instead return a doubleword encoding the wrong page, one cycle after the request. Each test read therefore predicts both its hit or miss outcome and its return cycle. The sequences are chosen so that the replacement order, random-mode passes and shadow flips each decide whether a later read fetches.

// File: rtl/frpb_pkg.sv
package frpb_pkg;
  localparam int ADDR_W       = 17;
  localparam int PAGE_BYTES   = 32;
  localparam int DATA_W       = 64;
  localparam int NUM_BUF      = 2;
  localparam int SHADOW_BYTES = 512;
  localparam int PAGE_W       = PAGE_BYTES * 8;
  localparam int DW_PER_PAGE  = PAGE_W / DATA_W;
  localparam int DW_SEL_W     = $clog2(DW_PER_PAGE);
  localparam int OFS_W        = DW_SEL_W + 1;
  localparam int TAG_W        = ADDR_W - OFS_W;
  localparam int SHADOW_PG_W  = $clog2(SHADOW_BYTES / PAGE_BYTES);

  typedef logic [TAG_W-1:0] pageTag_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture pending miss
    logic loadHit;    // return doubleword from a buffer
    logic hitWay;
    logic loadFetch;  // return doubleword from fetched page
    logic fillEn;     // store fetched page
    logic fillWay;
  } dpStrobe_t;
endpackage

// File: rtl/frpb_data.sv
module frpb_data
  import frpb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                shadowSel,
  input  logic [PAGE_W-1:0]   pageData,
  output logic [NUM_BUF-1:0]  tagMatch,
  output logic [DATA_W-1:0]   rdData,
  output pageTag_t            fetchAddr,
  output logic                fetchShadow
);
  pageTag_t              reqTag;
  logic [DW_SEL_W-1:0]   reqDw;
  logic [DW_SEL_W-1:0]   pendDw;
  logic                  unusedAddrLsb;

  logic [PAGE_W-1:0] pageMem  [NUM_BUF];
  pageTag_t          tagMem   [NUM_BUF];
  logic              tagShadow[NUM_BUF];

  assign unusedAddrLsb = rdAddr[0];
  assign reqDw         = rdAddr[1 +: DW_SEL_W];

  always_comb begin
    reqTag = rdAddr[ADDR_W-1:OFS_W];
    if (shadowSel) reqTag = pageTag_t'(rdAddr[OFS_W +: SHADOW_PG_W]);
  end

  generate
    for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tagMem[g]    <= '0;
          tagShadow[g] <= 1'b0;
        end else if (strobe.fillEn && strobe.fillWay == 1'(g)) begin
          tagMem[g]    <= fetchAddr;
          tagShadow[g] <= fetchShadow;
        end
      end
      always_ff @(posedge clk) begin
        if (strobe.fillEn && strobe.fillWay == 1'(g)) pageMem[g] <= pageData;
      end
      assign tagMatch[g] = (tagMem[g] == reqTag) && (tagShadow[g] == shadowSel);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr   <= '0;
      fetchShadow <= 1'b0;
      pendDw      <= '0;
    end else if (strobe.latchReq) begin
      fetchAddr   <= reqTag;
      fetchShadow <= shadowSel;
      pendDw      <= reqDw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobe.loadHit)   rdData <= pageMem[strobe.hitWay][reqDw*DATA_W +: DATA_W];
    else if (strobe.loadFetch) rdData <= pageData[pendDw*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/frpb_ctrl.sv
module frpb_ctrl
  import frpb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic               randomMode,
  input  logic               shadowSel,
  input  logic [NUM_BUF-1:0] tagMatch,
  input  logic               pageReady,
  output dpStrobe_t          strobe,
  output logic               busy,
  output logic               fetchReq,
  output logic               rdValid,
  output logic               wrAck
);
  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} state_t;

  state_t             state;
  logic [NUM_BUF-1:0] bufValid;
  logic [NUM_BUF-1:0] hitVec;
  logic               lruWay;
  logic               shadowPrev;
  logic               shadowFlip;
  logic               pendRandom;
  logic               accept;
  logic               isHit;
  logic               victim;
  logic               done;

  assign shadowFlip = shadowSel ^ shadowPrev;
  assign hitVec     = tagMatch & bufValid & {NUM_BUF{~shadowFlip}};
  assign isHit      = |hitVec;
  assign accept     = (state == ST_IDLE) && rdReq;
  assign done       = (state == ST_FETCH) && pageReady;
  assign busy       = (state == ST_FETCH);
  assign fetchReq   = (state == ST_FETCH);

  always_comb begin
    if (!bufValid[0])      victim = 1'b0;
    else if (!bufValid[1]) victim = 1'b1;
    else                   victim = lruWay;
  end

  always_comb begin
    strobe.latchReq  = accept && !isHit;
    strobe.loadHit   = accept && isHit;
    strobe.hitWay    = hitVec[1];
    strobe.loadFetch = done;
    strobe.fillEn    = done && !pendRandom;
    strobe.fillWay   = victim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bufValid   <= '0;
      lruWay     <= 1'b0;
      shadowPrev <= 1'b0;
      pendRandom <= 1'b0;
      rdValid    <= 1'b0;
      wrAck      <= 1'b0;
    end else begin
      shadowPrev <= shadowSel;
      wrAck      <= wrReq;
      rdValid    <= strobe.loadHit || done;
      if (strobe.latchReq) begin
        state      <= ST_FETCH;
        pendRandom <= randomMode;
      end else if (done) begin
        state <= ST_IDLE;
      end
      if (shadowFlip)         bufValid         <= '0;
      else if (strobe.fillEn) bufValid[victim] <= 1'b1;
      if (strobe.loadHit)     lruWay <= ~strobe.hitWay;
      else if (strobe.fillEn) lruWay <= ~victim;
    end
  end
endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import frpb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               randomMode,
  input  logic               shadowSel,
  output logic               busy,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               wrAck,
  output logic               fetchReq,
  output logic [TAG_W-1:0]   fetchAddr,
  output logic               fetchShadow,
  input  logic               pageReady,
  input  logic [PAGE_W-1:0]  pageData
);
  dpStrobe_t          strobe;
  logic [NUM_BUF-1:0] tagMatch;

  frpb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq),
    .randomMode(randomMode), .shadowSel(shadowSel), .tagMatch(tagMatch),
    .pageReady(pageReady), .strobe(strobe), .busy(busy),
    .fetchReq(fetchReq), .rdValid(rdValid), .wrAck(wrAck)
  );

  frpb_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr),
    .shadowSel(shadowSel), .pageData(pageData), .tagMatch(tagMatch),
    .rdData(rdData), .fetchAddr(fetchAddr), .fetchShadow(fetchShadow)
  );
endmodule

// File: rtl/flash_page_reader_chk.sv
module flash_page_reader_chk
  import frpb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             wrReq,
  input logic             shadowSel,
  input logic             busy,
  input logic             rdValid,
  input logic             wrAck,
  input logic             fetchReq,
  input logic [TAG_W-1:0] fetchAddr,
  input logic             fetchShadow,
  input logic             pageReady
);
  p_hit_or_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !busy |=> rdValid || fetchReq);

  p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && pageReady |=> rdValid && !fetchReq);

  p_fetch_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && $past(fetchReq) |-> $stable(fetchAddr) && $stable(fetchShadow));

  p_flip_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !busy && (shadowSel != $past(shadowSel)) |=> fetchReq);

  p_wr_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> wrAck);

  p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !rdReq && !busy |=> !fetchReq && !rdValid);

  p_shadow_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchShadow |-> fetchAddr[TAG_W-1:SHADOW_PG_W] == '0);

  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !pageReady |=> fetchReq && busy);
endmodule

bind flash_page_reader flash_page_reader_chk u_chk (.*);

// File: tb/flash_page_reader_test.sv
module flash_page_reader_test;
  import frpb_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, rdReq, wrReq, randomMode, shadowSel;
  logic [ADDR_W-1:0] rdAddr;
  logic              busy, rdValid, wrAck, fetchReq, fetchShadow, pageReady;
  logic [DATA_W-1:0] rdData;
  logic [TAG_W-1:0]  fetchAddr;
  logic [PAGE_W-1:0] pageData;

  flash_page_reader uut (.*);

  int nChecks = 0, nFails = 0, cycle = 0, fetchCount = 0, readyCycle = -10;
  logic [DATA_W-1:0] expQ[$];
  pageTag_t expFetchAddr;
  logic     expFetchShadow;

  always @(posedge clk) cycle++;

  function automatic logic [DATA_W-1:0] dwVal(input logic sh, input pageTag_t t, input int k);
    return {8'hC3, 7'd0, sh, 2'd0, t, 6'd0, 2'(k), 24'h5A5A5A};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // array core model: variable latency, page content encodes its own address
  initial begin
    int lat = 1;
    pageReady = 1'b0;
    pageData  = '0;
    forever begin
      @(negedge clk);
      if (fetchReq) begin
        fetchCount++;
        check(fetchAddr == expFetchAddr, "R3", "fetch address", 64'(fetchAddr), 64'(expFetchAddr));
        check(fetchShadow == expFetchShadow, "R8", "fetch shadow flag", 64'(fetchShadow), 64'(expFetchShadow));
        repeat (lat) @(negedge clk);
        for (int k = 0; k < DW_PER_PAGE; k++)
          pageData[k*DATA_W +: DATA_W] = dwVal(fetchShadow, fetchAddr, k);
        pageReady  = 1'b1;
        readyCycle = cycle;
        @(negedge clk);
        pageReady = 1'b0;
        lat = lat % 4 + 1;
      end
    end
  end

  // monitor: scoreboard pop on every returned doubleword
  initial begin
    forever begin
      @(negedge clk);
      if (rdValid) begin
        if (expQ.size() == 0) check(1'b0, "R2", "unexpected rdValid", rdData, '0);
        else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R3", "read data", rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 64'(cycle), 0);
    finishRun();
  end

  task automatic doRead(input logic [ADDR_W-1:0] addr, input logic sh, input logic rnd,
                        input bit expMiss, input string req);
    pageTag_t t;
    int f0, c0;
    t = sh ? pageTag_t'(addr[OFS_W +: SHADOW_PG_W]) : addr[ADDR_W-1:OFS_W];
    @(negedge clk);
    while (busy) @(negedge clk);
    expFetchAddr   = t;
    expFetchShadow = sh;
    f0 = fetchCount;
    c0 = cycle;
    rdAddr = addr; shadowSel = sh; randomMode = rnd; rdReq = 1'b1;
    expQ.push_back(dwVal(sh, t, int'(addr[2:1])));
    @(negedge clk);
    rdReq = 1'b0;
    while (!rdValid) @(negedge clk);
    if (expMiss) begin
      check(fetchCount == f0 + 1, req, "miss fetch count", 64'(fetchCount - f0), 1);
      check(cycle == readyCycle + 1, req, "miss return cycle", 64'(cycle - readyCycle), 1);
    end else begin
      check(fetchCount == f0, req, "hit fetch count", 64'(fetchCount - f0), 0);
      check(cycle == c0 + 1, req, "hit return cycle", 64'(cycle - c0), 1);
    end
  endtask

  localparam logic [ADDR_W-1:0] A  = {14'h1234, 3'b010};
  localparam logic [ADDR_W-1:0] A2 = {14'h1234, 3'b111};
  localparam logic [ADDR_W-1:0] B  = {14'h0567, 3'b001};
  localparam logic [ADDR_W-1:0] C  = {14'h3FFF, 3'b100};
  localparam logic [ADDR_W-1:0] D  = {14'h0002, 3'b110};
  localparam logic [ADDR_W-1:0] S  = {14'h2AB5, 3'b011};
  localparam logic [ADDR_W-1:0] N5 = {14'h0005, 3'b010};

  initial begin
    int f0;
    rstN = 1'b0; rdReq = 1'b0; wrReq = 1'b0; randomMode = 1'b0; shadowSel = 1'b0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdValid && !fetchReq && !wrAck, "R1", "reset outputs",
          64'({busy, rdValid, fetchReq, wrAck}), 0);

    doRead(A,  1'b0, 1'b0, 1, "R1");   // empty after reset
    doRead(A2, 1'b0, 1'b0, 0, "R3");   // other doubleword, bit0 set
    doRead(B,  1'b0, 1'b0, 1, "R4");   // fills invalid buffer 1
    doRead(A,  1'b0, 1'b0, 0, "R1");
    doRead(B,  1'b0, 1'b0, 0, "R1");
    doRead(C,  1'b0, 1'b0, 1, "R4");   // replaces A (least recent)
    doRead(B,  1'b0, 1'b0, 0, "R4");
    doRead(A,  1'b0, 1'b0, 1, "R4");   // A evicted earlier; replaces C

    doRead(D,  1'b0, 1'b1, 1, "R5");   // random pass, not stored
    doRead(A,  1'b0, 1'b0, 0, "R5");
    doRead(B,  1'b0, 1'b0, 0, "R5");
    doRead(D,  1'b0, 1'b0, 1, "R5");   // still a miss, now replaces A
    doRead(D,  1'b0, 1'b0, 0, "R5");

    // writes are acknowledged only
    @(negedge clk);
    f0 = fetchCount;
    rdAddr = C; wrReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0;
    check(wrAck == 1'b1, "R7", "write ack", 64'(wrAck), 1);
    check(!fetchReq && !rdValid, "R7", "write side effects", 64'({fetchReq, rdValid}), 0);
    @(negedge clk);
    check(wrAck == 1'b0, "R7", "write ack pulse", 64'(wrAck), 0);
    check(fetchCount == f0, "R7", "write fetch count", 64'(fetchCount - f0), 0);
    doRead(B,  1'b0, 1'b0, 0, "R7");
    doRead(D,  1'b0, 1'b0, 0, "R7");

    // shadow region
    doRead(S,  1'b1, 1'b0, 1, "R8");
    doRead(S,  1'b1, 1'b0, 0, "R8");
    doRead(B,  1'b0, 1'b0, 1, "R6");   // flip clears buffered B
    doRead(B,  1'b0, 1'b0, 0, "R6");
    doRead(N5, 1'b0, 1'b0, 1, "R8");   // normal page 5 does not alias shadow page 5
    doRead(N5, 1'b0, 1'b0, 0, "R8");

    // double flip with no read in between
    @(negedge clk); shadowSel = 1'b1;
    @(negedge clk); shadowSel = 1'b0;
    doRead(N5, 1'b0, 1'b0, 1, "R6");

    // read strobe while busy is dropped
    @(negedge clk);
    f0 = fetchCount;
    expFetchAddr = C[ADDR_W-1:OFS_W]; expFetchShadow = 1'b0;
    rdAddr = C; rdReq = 1'b1;
    expQ.push_back(dwVal(1'b0, C[ADDR_W-1:OFS_W], int'(C[2:1])));
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy after miss", 64'(busy), 1);
    rdAddr = A;
    @(negedge clk);
    rdReq = 1'b0;
    while (!rdValid) @(negedge clk);
    check(busy == 1'b0, "R9", "busy released", 64'(busy), 0);
    repeat (8) @(negedge clk);
    check(fetchCount == f0 + 1, "R9", "fetches for held strobe", 64'(fetchCount - f0), 1);
    check(expQ.size() == 0, "R9", "pending results", 64'(expQ.size()), 0);

    finishRun();
  end
endmodule